// File: doc/BRIEF.md
# Byte-Addressed Main Store with Two Stream-Mapped Locations

This block is the main store behind a small 16-bit accumulator CPU. The CPU side moves either one byte or a two-byte word per request over a 16-bit address space. A word is stored big-endian: the byte at the request address is the high byte, and the byte at the next address is the low byte. The address of a word is always the address of its first byte.

Two locations in the address space do not reach storage in one direction each. A read that touches 0xFC15 takes its byte from an input character stream. A write that touches 0xFC16 sends its byte to an output character stream. Both streams use valid/ready handshakes. While the stream partner is not ready, the CPU request is held by keeping `cpu_ready` low. A separate single-byte write port loads the store before a program runs. That port wins any cycle it shares with the CPU.

Storage is split by the address LSB into an even bank and an odd bank. Because of this split, both bytes of a word are reached in one cycle. The store holds 2**MEM_AW bytes. With MEM_AW = 16 it covers the full 64K space. With smaller values, the upper address bits are ignored, so the contents repeat across the space.

Top module: `mmio_byte_mem`

## Requirements
- R1: A byte write (`cpu_word`=0) to a storage address stores `cpu_wdata[7:0]`. A later byte read of that address returns it on `cpu_rdata[7:0]`, with `cpu_rdata[15:8]` = 0x00.
- R2: In a word access (`cpu_word`=1) at address A, byte A maps to bits 15:8 and byte A+1 maps to bits 7:0. This holds for both reads and writes.
- R3: The address of the second byte wraps: a word at 0xFFFF uses bytes 0xFFFF and 0x0000.
- R4: A read whose byte (first or second) lies at 0xFC15 takes that byte from `in_data` instead of storage. `in_ready` is high while that read is pending. The stream byte is consumed in the cycle where `in_valid` and `in_ready` are both high.
- R5: During such a read, `cpu_ready` stays low until `in_valid` is high, and it rises in that same cycle.
- R6: A write whose byte lies at 0xFC16 drives that byte on `out_data` with `out_valid` high. `cpu_ready` stays low until `out_ready` is high. The storage byte at 0xFC16 is left unchanged.
- R7: A read of 0xFC16 and a write of 0xFC15 are ordinary storage accesses. Neither raises `in_ready` or `out_valid`.
- R8: While `dbg_we` is high, `dbg_wdata` is written at `dbg_addr`. In that cycle `cpu_ready`, `in_ready` and `out_valid` are low, and the CPU request has no effect.
- R9: While `rst_n` is low, `cpu_ready`, `in_ready` and `out_valid` are low, and no storage byte changes.
- R10: Storage holds 2**MEM_AW bytes, and address bits at or above MEM_AW are ignored. With the default MEM_AW = 10, address 0x0405 names the same byte as 0x0005.
- R11: An access that touches no stream location completes with `cpu_ready` high in the cycle of the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_word | input | 1 | 1 = two-byte word, 0 = single byte |
| cpu_addr | input | 16 | Byte address of the first byte |
| cpu_wdata | input | 16 | Write data (byte access uses bits 7:0) |
| cpu_rdata | output | 16 | Read data, valid while `cpu_ready` is high |
| cpu_ready | output | 1 | Access completes this cycle |
| in_valid | input | 1 | Input stream has a byte |
| in_data | input | 8 | Input stream byte |
| in_ready | output | 1 | Input byte is being taken |
| out_valid | output | 1 | Output stream byte is offered |
| out_data | output | 8 | Output stream byte |
| out_ready | input | 1 | Output stream accepts the byte |
| dbg_we | input | 1 | Loader byte write strobe |
| dbg_addr | input | 16 | Loader byte address |
| dbg_wdata | input | 8 | Loader byte data |

## Verification
Read data, `cpu_ready` and the stream handshakes are combinational from the request and stream inputs. So the bench checks them one time unit after it drives a request at the falling edge, which is before the next rising edge. Stored bytes change at the rising edge where `cpu_ready` (or `dbg_we`) is high. The bench therefore reads them back only in a later request, never in the same cycle. Stall cases hold the request over several cycles and check in each cycle that ready is still low. They then check that ready rises in the same cycle the partner handshake arrives.

// File: rtl/mmio_mem_pkg.sv
package mmio_mem_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned ADDR_W   = 16;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned LANES    = 2;
    localparam logic [ADDR_W-1:0] STREAM_IN_ADDR  = 16'hFC15;
    localparam logic [ADDR_W-1:0] STREAM_OUT_ADDR = 16'hFC16;

    // Per-access steering computed by the decoder; lane 0 is the first byte.
    typedef struct packed {
        logic             ready;
        logic             in_pop;
        logic             out_push;
        logic [LANES-1:0] lane_in;
        logic [LANES-1:0] lane_out;
        logic [LANES-1:0] store_we;
    } mem_ctl_t;
endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_mem_pkg::*;
(
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic              cpu_word,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              in_valid,
    input  logic              out_ready,
    input  logic              dbg_we,
    output logic [ADDR_W-1:0] addr_next,
    output mem_ctl_t          ctl
);
    timeunit 1ns;
    timeprecision 1ps;

    mem_ctl_t ctl_d;
    logic     live;

    assign addr_next = cpu_addr + 16'd1;   // wraps 0xFFFF -> 0x0000
    assign live      = rst_n & cpu_req & ~dbg_we;

    always_comb begin
        ctl_d = '0;
        ctl_d.lane_in[0]  = ~cpu_we & (cpu_addr == STREAM_IN_ADDR);
        ctl_d.lane_in[1]  = ~cpu_we & cpu_word & (addr_next == STREAM_IN_ADDR);
        ctl_d.lane_out[0] =  cpu_we & (cpu_addr == STREAM_OUT_ADDR);
        ctl_d.lane_out[1] =  cpu_we & cpu_word & (addr_next == STREAM_OUT_ADDR);
        ctl_d.in_pop      = live & (|ctl_d.lane_in);
        ctl_d.out_push    = live & (|ctl_d.lane_out);
        if (|ctl_d.lane_in) begin
            ctl_d.ready = live & in_valid;
        end else if (|ctl_d.lane_out) begin
            ctl_d.ready = live & out_ready;
        end else begin
            ctl_d.ready = live;
        end
        ctl_d.store_we[0] = ctl_d.ready & cpu_we & ~ctl_d.lane_out[0];
        ctl_d.store_we[1] = ctl_d.ready & cpu_we & cpu_word & ~ctl_d.lane_out[1];
    end

    assign ctl = ctl_d;
endmodule

// File: rtl/mmio_bank.sv
module mmio_bank #(
    parameter int unsigned ROW_W  = 9,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ROW_W-1:0]  wrow,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROW_W-1:0]  rrow,
    output logic [DATA_W-1:0] rdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned DEPTH = 1 << ROW_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[wrow] <= wdata;
        end
    end

    assign rdata = mem_q[rrow];
endmodule

// File: rtl/mmio_byte_mem.sv
module mmio_byte_mem
    import mmio_mem_pkg::*;
#(
    parameter int unsigned MEM_AW = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic        cpu_word,
    input  logic [15:0] cpu_addr,
    input  logic [15:0] cpu_wdata,
    output logic [15:0] cpu_rdata,
    output logic        cpu_ready,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    output logic        in_ready,
    output logic        out_valid,
    output logic [7:0]  out_data,
    input  logic        out_ready,
    input  logic        dbg_we,
    input  logic [15:0] dbg_addr,
    input  logic [7:0]  dbg_wdata
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int unsigned ROW_W = MEM_AW - 1;

    mem_ctl_t          ctl;
    logic [ADDR_W-1:0] addr_next;
    logic [BYTE_W-1:0] lane_wd  [LANES];
    logic [BYTE_W-1:0] lane_rd  [LANES];
    logic [BYTE_W-1:0] store_rd [LANES];
    logic [BYTE_W-1:0] bank_rd  [LANES];
    logic              dbg_live;

    mmio_decode u_decode (
        .rst_n     (rst_n),
        .cpu_req   (cpu_req),
        .cpu_we    (cpu_we),
        .cpu_word  (cpu_word),
        .cpu_addr  (cpu_addr),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .dbg_we    (dbg_we),
        .addr_next (addr_next),
        .ctl       (ctl)
    );

    assign dbg_live   = rst_n & dbg_we;
    // big-endian: first byte carries the high half of a word
    assign lane_wd[0] = cpu_word ? cpu_wdata[15:8] : cpu_wdata[7:0];
    assign lane_wd[1] = cpu_wdata[7:0];

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        localparam logic BANK_ID = (b == 1);
        logic             sel_second;
        logic             dbg_hit;
        logic             cpu_wr;
        logic [ROW_W-1:0] cpu_row;
        logic [BYTE_W-1:0] cpu_byte;

        assign sel_second = (cpu_addr[0] != BANK_ID);
        assign cpu_row    = sel_second ? addr_next[MEM_AW-1:1] : cpu_addr[MEM_AW-1:1];
        assign cpu_wr     = sel_second ? ctl.store_we[1] : ctl.store_we[0];
        assign cpu_byte   = sel_second ? lane_wd[1] : lane_wd[0];
        assign dbg_hit    = dbg_live & (dbg_addr[0] == BANK_ID);

        mmio_bank #(.ROW_W(ROW_W), .DATA_W(BYTE_W)) u_bank (
            .clk   (clk),
            .we    (dbg_hit | cpu_wr),
            .wrow  (dbg_hit ? dbg_addr[MEM_AW-1:1] : cpu_row),
            .wdata (dbg_hit ? dbg_wdata : cpu_byte),
            .rrow  (cpu_row),
            .rdata (bank_rd[b])
        );
    end

    if (MEM_AW < ADDR_W) begin : g_alias
        logic dbg_hi_unused;
        assign dbg_hi_unused = ^dbg_addr[ADDR_W-1:MEM_AW];
    end

    assign store_rd[0] = bank_rd[cpu_addr[0]];
    assign store_rd[1] = bank_rd[addr_next[0]];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_rd[k] = ctl.lane_in[k] ? in_data : store_rd[k];
    end

    assign cpu_rdata = cpu_word ? {lane_rd[0], lane_rd[1]} : {8'h00, lane_rd[0]};
    assign cpu_ready = ctl.ready;
    assign in_ready  = ctl.in_pop;
    assign out_valid = ctl.out_push;
    assign out_data  = ctl.lane_out[0] ? lane_wd[0] : lane_wd[1];
endmodule

// File: rtl/mmio_byte_mem_chk.sv
module mmio_byte_mem_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic        cpu_word,
    input logic [15:0] cpu_addr,
    input logic [15:0] cpu_wdata,
    input logic [15:0] cpu_rdata,
    input logic        cpu_ready,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic        dbg_we
);
    timeunit 1ns;
    timeprecision 1ps;

    p_rd_after_wr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_ready && !cpu_we && !cpu_word && cpu_addr != 16'hFC15
         && $past(cpu_req && cpu_ready && cpu_we && !cpu_word && cpu_addr != 16'hFC16)
         && cpu_addr == $past(cpu_addr))
        |-> cpu_rdata == {8'h00, $past(cpu_wdata[7:0])});

    p_in_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && !in_valid) |-> !cpu_ready);

    p_out_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !cpu_ready);

    p_in_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (cpu_req && !cpu_we));

    p_out_write_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (cpu_req && cpu_we));

    p_loader_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_we |-> (!cpu_ready && !in_ready && !out_valid));

    p_no_wait_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !dbg_we && !cpu_word && cpu_addr != 16'hFC15 && cpu_addr != 16'hFC16)
        |-> cpu_ready);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_quiet_r9: assert (!cpu_ready && !in_ready && !out_valid)
                else $error("outputs active during reset");
        end
    end
endmodule

bind mmio_byte_mem mmio_byte_mem_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_word  (cpu_word),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_rdata (cpu_rdata),
    .cpu_ready (cpu_ready),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .dbg_we    (dbg_we)
);

// File: tb/mmio_byte_mem_tb_top.sv
module mmio_byte_mem_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0, cpu_word = 1'b0;
    logic [15:0] cpu_addr = '0, cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ready;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready, out_valid;
    logic [7:0]  out_data;
    logic        out_ready = 1'b0;
    logic        dbg_we = 1'b0;
    logic [15:0] dbg_addr = '0;
    logic [7:0]  dbg_wdata = '0;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    mmio_byte_mem dut_i (.*);

    typedef struct packed {
        logic        we;
        logic        word;
        logic [15:0] addr;
        logic [15:0] wdata;
        logic [15:0] exp;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 16'h0100, 16'h0000, 16'h00A5, 8'd1},   // R1 byte read
        '{1'b0, 1'b1, 16'h0100, 16'h0000, 16'hA53C, 8'd2},   // R2 word read
        '{1'b1, 1'b1, 16'h0200, 16'h1234, 16'h0000, 8'd2},   // R2 word write
        '{1'b0, 1'b0, 16'h0200, 16'h0000, 16'h0012, 8'd2},   // R2 high byte first
        '{1'b0, 1'b0, 16'h0201, 16'h0000, 16'h0034, 8'd2},   // R2 low byte second
        '{1'b1, 1'b0, 16'h0300, 16'h00EE, 16'h0000, 8'd1},   // R1 byte write
        '{1'b0, 1'b0, 16'h0300, 16'h0000, 16'h00EE, 8'd1},   // R1 read back
        '{1'b1, 1'b1, 16'hFFFF, 16'hBEEF, 16'h0000, 8'd3},   // R3 wrapping write
        '{1'b0, 1'b0, 16'hFFFF, 16'h0000, 16'h00BE, 8'd3},   // R3
        '{1'b0, 1'b0, 16'h0000, 16'h0000, 16'h00EF, 8'd3},   // R3
        '{1'b0, 1'b1, 16'hFFFF, 16'h0000, 16'hBEEF, 8'd3},   // R3 wrapping read
        '{1'b0, 1'b0, 16'h0405, 16'h0000, 16'h0077, 8'd10},  // R10 alias of 0x0005
        '{1'b0, 1'b0, 16'hFC16, 16'h0000, 16'h0066, 8'd7},   // R7 read of output loc
        '{1'b1, 1'b0, 16'hFC15, 16'h005A, 16'h0000, 8'd7},   // R7 write of input loc
        '{1'b0, 1'b0, 16'h0015, 16'h0000, 16'h005A, 8'd7}    // R7 alias of 0xFC15
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        dbg_we = 1'b1; dbg_addr = a; dbg_wdata = d;
        @(posedge clk); #1;
        dbg_we = 1'b0;
    endtask

    task automatic put_req(input logic we, input logic word, input logic [15:0] a,
                           input logic [15:0] wd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_word = word; cpu_addr = a; cpu_wdata = wd;
        #1;
    endtask

    task automatic end_req;
        @(posedge clk); #1;
        cpu_req = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    endtask

    task automatic do_read(input logic word, input logic [15:0] a, input logic [15:0] exp,
                           input string req);
        put_req(1'b0, word, a, 16'h0);
        check(req, {15'd0, cpu_ready}, 16'd1);
        check(req, cpu_rdata, exp);
        end_req();
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R9: outputs quiet and nothing stored while in reset
        put_req(1'b1, 1'b0, 16'hFC16, 16'h0099);
        check("R9 reset ready", {15'd0, cpu_ready}, 16'd0);
        check("R9 reset out_valid", {15'd0, out_valid}, 16'd0);
        cpu_word = 1'b0; cpu_we = 1'b0; cpu_addr = 16'hFC15; in_valid = 1'b1; #1;
        check("R9 reset in_ready", {15'd0, in_ready}, 16'd0);
        end_req();
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        poke(16'h0100, 8'hA5); poke(16'h0101, 8'h3C); poke(16'hFC16, 8'h66);
        poke(16'hFC14, 8'h22); poke(16'h0005, 8'h77); poke(16'h0120, 8'h11);

        // R9: a write held during reset leaves storage alone
        rst_n = 1'b0;
        put_req(1'b1, 1'b0, 16'h0120, 16'h0099);
        check("R9 reset ready", {15'd0, cpu_ready}, 16'd0);
        end_req();
        rst_n = 1'b1;
        do_read(1'b0, 16'h0120, 16'h0011, "R9 no write in reset");

        // vector table: storage-only accesses, R1 R2 R3 R7 R10 R11
        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = $sformatf("R%0d vec%0d", VECS[i].tag, i);
            put_req(VECS[i].we, VECS[i].word, VECS[i].addr, VECS[i].wdata);
            check({tg, " R11 ready"}, {15'd0, cpu_ready}, 16'd1);
            check({tg, " R7 no stream"}, {14'd0, in_ready, out_valid}, 16'd0);
            if (!VECS[i].we) check(tg, cpu_rdata, VECS[i].exp);
            end_req();
        end

        // R4 R5: input read stalls until the stream offers a byte
        put_req(1'b0, 1'b0, 16'hFC15, 16'h0);
        for (int c = 0; c < 3; c++) begin
            check("R5 stall ready", {15'd0, cpu_ready}, 16'd0);
            check("R4 in_ready pending", {15'd0, in_ready}, 16'd1);
            @(negedge clk); #1;
        end
        in_valid = 1'b1; in_data = 8'h41; #1;
        check("R5 ready on valid", {15'd0, cpu_ready}, 16'd1);
        check("R4 input byte", cpu_rdata, 16'h0041);
        end_req();

        // R4: input in the second byte of a word
        put_req(1'b0, 1'b1, 16'hFC14, 16'h0);
        in_valid = 1'b1; in_data = 8'h43; #1;
        check("R4 word second byte", cpu_rdata, 16'h2243);
        check("R4 in_ready", {15'd0, in_ready}, 16'd1);
        end_req();

        // R4: input in the first byte, second from storage at 0xFC16
        put_req(1'b0, 1'b1, 16'hFC15, 16'h0);
        in_valid = 1'b1; in_data = 8'h44; #1;
        check("R4 word first byte", cpu_rdata, 16'h4466);
        end_req();

        // R6: output write stalls until the stream accepts
        put_req(1'b1, 1'b0, 16'hFC16, 16'h0048);
        for (int c = 0; c < 3; c++) begin
            check("R6 stall ready", {15'd0, cpu_ready}, 16'd0);
            check("R6 out_valid", {15'd0, out_valid}, 16'd1);
            check("R6 out_data", {8'd0, out_data}, 16'h0048);
            @(negedge clk); #1;
        end
        out_ready = 1'b1; #1;
        check("R6 ready on accept", {15'd0, cpu_ready}, 16'd1);
        end_req();
        do_read(1'b0, 16'hFC16, 16'h0066, "R6 storage untouched");

        // R6: word write at 0xFC15 stores first byte, streams second
        put_req(1'b1, 1'b1, 16'hFC15, 16'h7172);
        out_ready = 1'b1; #1;
        check("R6 word out_data", {8'd0, out_data}, 16'h0072);
        check("R6 word ready", {15'd0, cpu_ready}, 16'd1);
        end_req();
        do_read(1'b0, 16'h0015, 16'h0071, "R6 first byte stored");
        do_read(1'b0, 16'hFC16, 16'h0066, "R6 second byte not stored");

        // R8: loader write wins over a held CPU write
        put_req(1'b1, 1'b0, 16'h0140, 16'h0055);
        dbg_we = 1'b1; dbg_addr = 16'h0141; dbg_wdata = 8'h99; #1;
        check("R8 cpu blocked", {15'd0, cpu_ready}, 16'd0);
        @(posedge clk); #1;
        dbg_we = 1'b0;
        @(negedge clk); #1;
        check("R8 cpu resumes", {15'd0, cpu_ready}, 16'd1);
        end_req();
        do_read(1'b1, 16'h0140, 16'h5599, "R8 both bytes");

        // R8: loader cycle suppresses input pop
        put_req(1'b0, 1'b0, 16'hFC15, 16'h0);
        in_valid = 1'b1; dbg_we = 1'b1; dbg_addr = 16'h0150; dbg_wdata = 8'h01; #1;
        check("R8 no pop", {14'd0, in_ready, cpu_ready}, 16'd0);
        end_req();
        dbg_we = 1'b0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule